// File: doc/BRIEF.md
# Masked Vector Bitwise XOR Lane

This block is one execution lane of a vector unit. It forms the bitwise exclusive-OR of two vector sources of up to 512 bits and writes the result into an image of the destination register. How many bits take part, what happens to the bits above them, and whether a writemask applies all depend on an encoding-class code. The encoding classes are two legacy widths (64 and 128 bits), a three-operand form at 128 or 256 bits, and a masked three-operand form at 128, 256 or 512 bits.

In the masked class, every element of 32 or 64 bits has its own mask bit. An element whose bit is clear either keeps its old destination value or is cleared to zero. The lowest element of the second source can also be copied to every element position when that source is marked as coming from memory.

The result is registered, so a new destination value appears one clock after its inputs. Decode, the register file and memory access all stay outside the block. Reset clears the output register.

Top module: `simd_xor_mask_unit`

## Requirements
- R1: For every bit written with a result, the output bit is 1 when the two operand bits differ and 0 when they match.
- R2: The `enc` codes select the active length: 0 = legacy, 64 bits; 1 = legacy, 128 bits; 2 = three-operand, 128 bits; 3 = three-operand, 256 bits; 4/5/6 = masked, 128/256/512 bits. Code 7 is reserved and yields an all-zero destination.
- R3: For codes 0 and 1 the first operand is `dst_old` and `src1` has no effect. For codes 2 to 6 the first operand is `src1`.
- R4: Bits above the active length keep their `dst_old` value for codes 0 and 1, and are zero for codes 2 to 6.
- R5: For codes 4 to 6, bit j of `kmask` governs element j. Elements are 32 bits wide when `esz64`=0 and 64 bits wide when `esz64`=1. An element is written with the result when its mask bit is 1 or when `nomask`=1.
- R6: A masked-off element takes its `dst_old` value when `zeroing`=0 and becomes zero when `zeroing`=1.
- R7: For codes 4 to 6 with `bcast`=1 and `src2_mem`=1, every element uses the lowest element of `src2` as its second operand: bits 31:0 for 32-bit elements, bits 63:0 for 64-bit elements.
- R8: `bcast`=1 with `src2_mem`=0 has no effect.
- R9: For codes 0 to 3, `kmask`, `nomask`, `zeroing` and `bcast` have no effect, and every element within the active length is written.
- R10: Bits of `kmask` at or above the active element count have no effect.
- R11: `dst_new` reflects the inputs of the previous rising clock edge. While `rst_n` is low, `dst_new` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc | input | 3 | Encoding class code |
| esz64 | input | 1 | Element size: 0 = 32 bits, 1 = 64 bits |
| src1 | input | 512 | First source for codes 2 to 6 |
| src2 | input | 512 | Second source |
| dst_old | input | 512 | Previous destination value |
| kmask | input | 16 | Per-element writemask |
| nomask | input | 1 | Writes all elements, ignoring `kmask` |
| zeroing | input | 1 | Masked-off elements: 1 = zero, 0 = keep |
| bcast | input | 1 | Request to broadcast the lowest element |
| src2_mem | input | 1 | Second source comes from memory |
| dst_new | output | 512 | New destination value, registered |

## Verification
On every cycle, the assertions check four things:
- the unmasked 512-bit XOR;
- zeroing and merging when the mask is empty;
- the cleared upper bits of the three-operand forms;
- the preserved upper bits of the legacy 128-bit form.

Partial masks, element-size pairing of mask bits, broadcast lane selection, the inert inputs of the unmasked classes, the reserved code and the reset value are shown only by the bench's scenarios, which compare against a bit-level model.

// File: rtl/sxm_pkg.sv
package sxm_pkg;

    localparam int unsigned CHUNK_W = 32;
    localparam int unsigned VEC_W   = 512;
    localparam int unsigned N_CHUNK = VEC_W / CHUNK_W;

    typedef enum logic [2:0] {
        ENC_LEG64  = 3'd0,
        ENC_LEG128 = 3'd1,
        ENC_TRI128 = 3'd2,
        ENC_TRI256 = 3'd3,
        ENC_MSK128 = 3'd4,
        ENC_MSK256 = 3'd5,
        ENC_MSK512 = 3'd6,
        ENC_RSVD   = 3'd7
    } enc_e;

    function automatic int unsigned active_bits(enc_e e);
        unique case (e)
            ENC_LEG64:                          return 64;
            ENC_LEG128, ENC_TRI128, ENC_MSK128: return 128;
            ENC_TRI256, ENC_MSK256:             return 256;
            ENC_MSK512:                         return 512;
            default:                            return 0;
        endcase
    endfunction

    function automatic logic is_legacy(enc_e e);
        return (e == ENC_LEG64) || (e == ENC_LEG128);
    endfunction

    function automatic logic is_masked(enc_e e);
        return (e == ENC_MSK128) || (e == ENC_MSK256) || (e == ENC_MSK512);
    endfunction

endpackage

// File: rtl/sxm_chunk_ctl.sv
module sxm_chunk_ctl
    import sxm_pkg::*;
#(
    parameter int unsigned NCH = N_CHUNK
) (
    input  enc_e             enc,
    input  logic             esz64,
    input  logic [NCH-1:0]   kmask,
    input  logic             nomask,
    input  logic             zeroing,
    output logic [NCH-1:0]   take_xor,
    output logic [NCH-1:0]   take_old
);
    logic [31:0] n_live;
    logic        leg;
    logic        msk;

    always_comb begin
        n_live = active_bits(enc) / CHUNK_W;
        leg    = is_legacy(enc);
        msk    = is_masked(enc);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        logic in_len;
        logic mbit;
        logic act;
        always_comb begin
            in_len = (32'(c) < n_live);
            mbit   = esz64 ? kmask[c/2] : kmask[c];
            act    = !msk || nomask || mbit;
            take_xor[c] = in_len && act;
            take_old[c] = in_len ? (!act && !zeroing) : leg;
        end
    end

endmodule

// File: rtl/sxm_operand_sel.sv
module sxm_operand_sel
    import sxm_pkg::*;
#(
    parameter int unsigned W = VEC_W
) (
    input  enc_e           enc,
    input  logic           esz64,
    input  logic           bcast,
    input  logic           src2_mem,
    input  logic [W-1:0]   src1,
    input  logic [W-1:0]   src2,
    input  logic [W-1:0]   dst_old,
    output logic [W-1:0]   opa,
    output logic [W-1:0]   opb
);
    localparam int unsigned NCH = W / CHUNK_W;

    logic spread;

    always_comb begin
        spread = is_masked(enc) && bcast && src2_mem;
        opa    = is_legacy(enc) ? dst_old : src1;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_b
        always_comb begin
            if (!spread)
                opb[c*CHUNK_W +: CHUNK_W] = src2[c*CHUNK_W +: CHUNK_W];
            else if (esz64)
                opb[c*CHUNK_W +: CHUNK_W] = src2[(c%2)*CHUNK_W +: CHUNK_W];
            else
                opb[c*CHUNK_W +: CHUNK_W] = src2[CHUNK_W-1:0];
        end
    end

endmodule

// File: rtl/simd_xor_mask_unit.sv
module simd_xor_mask_unit
    import sxm_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     enc,
    input  logic           esz64,
    input  logic [511:0]   src1,
    input  logic [511:0]   src2,
    input  logic [511:0]   dst_old,
    input  logic [15:0]    kmask,
    input  logic           nomask,
    input  logic           zeroing,
    input  logic           bcast,
    input  logic           src2_mem,
    output logic [511:0]   dst_new
);
    localparam int unsigned NCH = N_CHUNK;

    enc_e                enc_t;
    logic [VEC_W-1:0]    opa, opb, nxt;
    logic [NCH-1:0]      take_xor, take_old;

    assign enc_t = enc_e'(enc);

    sxm_chunk_ctl #(.NCH(NCH)) u_ctl (
        .enc      (enc_t),
        .esz64    (esz64),
        .kmask    (kmask),
        .nomask   (nomask),
        .zeroing  (zeroing),
        .take_xor (take_xor),
        .take_old (take_old)
    );

    sxm_operand_sel #(.W(VEC_W)) u_ops (
        .enc      (enc_t),
        .esz64    (esz64),
        .bcast    (bcast),
        .src2_mem (src2_mem),
        .src1     (src1),
        .src2     (src2),
        .dst_old  (dst_old),
        .opa      (opa),
        .opb      (opb)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_dp
        always_comb begin
            if (take_xor[c])
                nxt[c*CHUNK_W +: CHUNK_W] = opa[c*CHUNK_W +: CHUNK_W] ^ opb[c*CHUNK_W +: CHUNK_W];
            else if (take_old[c])
                nxt[c*CHUNK_W +: CHUNK_W] = dst_old[c*CHUNK_W +: CHUNK_W];
            else
                nxt[c*CHUNK_W +: CHUNK_W] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dst_new <= '0;
        else        dst_new <= nxt;
    end

    // Goes high one edge after reset release, so that every $past below
    // refers to an edge that was outside reset.
    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assert_full_xor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(enc) == 3'd6 && $past(nomask) && !$past(bcast))
        |-> dst_new == ($past(src1) ^ $past(src2)));

    assert_merge_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(enc) == 3'd6 && !$past(nomask) && $past(kmask) == 16'h0 && !$past(zeroing))
        |-> dst_new == $past(dst_old));

    assert_zero_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(enc) == 3'd6 && !$past(nomask) && $past(kmask) == 16'h0 && $past(zeroing))
        |-> dst_new == '0);

    assert_tri_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(enc) == 3'd3) |-> dst_new[511:256] == '0);

    assert_leg_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(enc) == 3'd1) |-> dst_new[511:128] == $past(dst_old[511:128]));

endmodule

// File: tb/tb_simd_xor_mask_unit.sv
`timescale 1ns/1ps
module tb_simd_xor_mask_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   enc = '0;
    logic         esz64 = 1'b0;
    logic [511:0] src1 = '0, src2 = '0, dst_old = '0;
    logic [15:0]  kmask = '0;
    logic         nomask = 1'b0, zeroing = 1'b0, bcast = 1'b0, src2_mem = 1'b0;
    logic [511:0] dst_new;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    simd_xor_mask_unit dut (
        .clk(clk), .rst_n(rst_n), .enc(enc), .esz64(esz64),
        .src1(src1), .src2(src2), .dst_old(dst_old), .kmask(kmask),
        .nomask(nomask), .zeroing(zeroing), .bcast(bcast),
        .src2_mem(src2_mem), .dst_new(dst_new)
    );

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Bit-level model built straight from the requirements.
    function automatic logic [511:0] model(
        logic [2:0] e, logic s64, logic [511:0] a1, logic [511:0] b2,
        logic [511:0] od, logic [15:0] k, logic nm, logic zr, logic bc, logic mem);
        logic [511:0] r;
        int  len;
        int  esz;
        bit  leg, msk;
        case (e)
            3'd0: len = 64;
            3'd1, 3'd2, 3'd4: len = 128;
            3'd3, 3'd5: len = 256;
            3'd6: len = 512;
            default: len = 0;
        endcase
        leg = (e <= 3'd1);
        msk = (e >= 3'd4) && (e <= 3'd6);
        esz = s64 ? 64 : 32;
        for (int i = 0; i < 512; i++) begin
            logic abit, bbit, act;
            abit = leg ? od[i] : a1[i];
            bbit = (msk && bc && mem) ? b2[i % esz] : b2[i];
            act  = !msk || nm || k[i / esz];
            if (i < len)
                r[i] = act ? (abit ^ bbit) : (zr ? 1'b0 : od[i]);
            else
                r[i] = leg ? od[i] : 1'b0;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [511:0] exp);
        checks++;
        if (dst_new !== exp) begin
            fails++;
            $display("FAIL %s enc=%0d esz64=%0b actual=%h expected=%h",
                     tag, enc, esz64, dst_new, exp);
        end
    endtask

    task automatic run(string tag, logic [2:0] e, logic s64, logic [15:0] k,
                       logic nm, logic zr, logic bc, logic mem);
        logic [511:0] exp;
        @(negedge clk);
        enc = e; esz64 = s64; kmask = k; nomask = nm; zeroing = zr;
        bcast = bc; src2_mem = mem;
        src1 = rnd512(); src2 = rnd512(); dst_old = rnd512();
        exp = model(e, s64, src1, src2, dst_old, k, nm, zr, bc, mem);
        @(posedge clk);
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin
        void'($urandom(32'd20260517));
        repeat (3) @(negedge clk);
        check("R11 reset", '0);
        rst_n = 1'b1;

        // Directed corners
        run("R1 full xor 512",          3'd6, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0);
        run("R2 legacy 64",             3'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R2 reserved code",         3'd7, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0);
        run("R3 legacy 128 src1 inert", 3'd1, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1);
        run("R4 tri 128 upper zero",    3'd2, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R4 tri 256 upper zero",    3'd3, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R5 mask 32b partial",      3'd6, 1'b0, 16'hA5C3, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R5 mask 64b partial",      3'd6, 1'b1, 16'h0059, 1'b0, 1'b1, 1'b0, 1'b0);
        run("R5 mask all ones",         3'd5, 1'b0, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0);
        run("R6 merge empty mask",      3'd6, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R6 zero empty mask",       3'd6, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
        run("R7 bcast 32b",             3'd6, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1);
        run("R7 bcast 64b masked",      3'd5, 1'b1, 16'h0009, 1'b0, 1'b0, 1'b1, 1'b1);
        run("R8 bcast no mem",          3'd6, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0);
        run("R9 tri 256 mask inert",    3'd3, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1);
        run("R9 legacy 64 mask inert",  3'd0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1);
        run("R10 high mask bits 128",   3'd4, 1'b0, 16'hFFF0, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R10 high mask bits 64b",   3'd5, 1'b1, 16'hFFF0, 1'b0, 1'b1, 1'b0, 1'b0);

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            logic [2:0] e;
            logic [15:0] k;
            e = 3'($urandom_range(0, 7));
            case ($urandom_range(0, 3))
                0: k = 16'h0000;
                1: k = 16'hFFFF;
                default: k = 16'($urandom);
            endcase
            run("R1 random", e, 1'($urandom), k, ($urandom_range(0, 3) == 0),
                1'($urandom), 1'($urandom), 1'($urandom));
        end

        // Back-to-back changes: output must follow the previous edge only (R11)
        begin
            logic [511:0] e1, e2;
            @(negedge clk);
            enc = 3'd6; nomask = 1'b1; bcast = 1'b0;
            src1 = rnd512(); src2 = rnd512();
            e1 = src1 ^ src2;
            @(negedge clk);
            check("R11 latency first", e1);
            src1 = rnd512();
            e2 = src1 ^ src2;
            check("R11 holds until edge", e1);
            @(negedge clk);
            check("R11 latency second", e2);
        end

        // Reset mid-run clears the output (R11)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears", '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule